// File: doc/BRIEF.md
# Gated Counter/Timer Channel (13-bit or 16-bit)

This block is one counter/timer channel of the kind found beside a small processor core. A count value is held in a low byte and a high byte, both reachable over a plain register bus. The channel either counts as a 13-bit value, with 5 bits from the low byte and 8 bits from the high byte, or as a full 16-bit value. Each increment comes from one of three sources: a falling edge on an external count pin, every system clock, or a one-cycle tick pulse from a prescaler outside the block.

A run bit enables counting. A gate option can make counting depend on an external gate pin as well. That pin is XORed with a polarity bit, so the gate can be high-active or low-active. This lets software measure the width of a pulse on the gate pin. When the count wraps to zero, a sticky overflow flag is set. Software loads the start value before it sets the run bit, and setting the run bit never changes the count.

There is no streaming data path. Every pin is a plain control or status signal, and register reads are combinational.

Top module: `gated_ctr_timer`

## Requirements
- R1: After reset, every register reads 0x00 and `ovf_flag` is 0.
- R2: Register map, selected by `reg_addr` on writes and by `reg_raddr` on reads:
  - Address 0 is control. Bit 0 is run and bit 1 is the overflow flag; the other bits read 0.
  - Address 1 is configuration. Bit 0 is wide (1 selects 16-bit mode). Bit 1 is gate_en. Bit 2 is gate_pol. Bit 3 is src_pin. Bit 4 is src_sys. The other bits read 0.
  - Address 2 is the count low byte and address 3 is the count high byte.
  - A write takes effect at the rising clock edge while `reg_we` is 1. `reg_rdata` follows `reg_raddr` combinationally.
- R3: With src_pin=0 and src_sys=1, the count increments on every clock edge at which counting is enabled.
- R4: With src_pin=0 and src_sys=0, the count increments on each clock edge at which `tick_in` is 1 and counting is enabled.
- R5: With src_pin=1, the count increments once for each falling edge of `cnt_pin`. The pin passes through a two-flop synchronizer first, and there is at most one increment per clock. The value of src_sys has no effect while src_pin=1.
- R6: Counting is enabled only when run=1 and either gate_en=0 or (synchronized `gate_pin` XOR gate_pol)=1.
- R7: Writing the run bit never loads or clears the count. Counting continues from the stored value.
- R8: With wide=0 the count is 13 bits. Low-byte bits 4:0 form the low part, and their carry increments the high byte. Low-byte bits 7:5 keep their written value.
- R9: With wide=1 the count is the 16-bit value {high, low}.
- R10: The overflow flag is set when an increment wraps the count to zero: 0x1FFF to 0 when wide=0, 0xFFFF to 0 when wide=1. It stays set until a control write with bit 1 = 0 clears it. A control write with bit 1 = 1 leaves the flag unchanged. If a wrap and a clearing write happen in the same cycle, the flag is set. `ovf_flag` drives the flag out of the block.
- R11: A write to the low byte or the high byte in a cycle cancels that cycle's increment. The written byte takes the written value and the other byte holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 8 | Read data (combinational) |
| cnt_pin | input | 1 | External count pin; its falling edges are counted |
| gate_pin | input | 1 | External gate pin |
| tick_in | input | 1 | Prescaled tick pulse, synchronous to `clk` |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The free-running system clock source is used to test exact increment counts over a timed run window. The resulting totals separate an off-by-one in run enable from a correct count. Tick pulses spaced apart show that only tick cycles are counted. Toggling `cnt_pin` with src_sys also set shows that the pin source takes precedence and that one increment occurs per falling edge. Three gate settings are run with the gate pin held low: gated with high-active polarity, gated with low-active polarity, and ungated. Together they show whether the polarity XOR and the gate enable are wired correctly. Start values of 0x1FFE, 0xFFFE and a low part of 0x1F exercise the wrap points of both widths and the carry from 5 to 8 bits. A byte write during counting shows whether the write takes priority over the increment.

// File: rtl/gct_pkg.sv
package gct_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTL = 2'd0,
    ADDR_CFG = 2'd1,
    ADDR_LO  = 2'd2,
    ADDR_HI  = 2'd3
  } gct_addr_e;

  typedef struct packed {
    logic src_sys;
    logic src_pin;
    logic gate_pol;
    logic gate_en;
    logic wide;
  } gct_cfg_t;

  localparam int CFG_W = $bits(gct_cfg_t);
endpackage

// File: rtl/gct_sync.sv
module gct_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gct_edge.sv
module gct_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;

  // R5
  one_fall_per_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/gct_inc_sel.sv
module gct_inc_sel
  import gct_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  gct_cfg_t cfg,
  input  logic     gate_s,
  input  logic     pin_fall,
  input  logic     tick_in,
  output logic     inc
);
  logic gate_ok;
  logic src_hit;

  assign gate_ok = ~cfg.gate_en | (gate_s ^ cfg.gate_pol);

  always_comb begin
    if (cfg.src_pin)      src_hit = pin_fall;
    else if (cfg.src_sys) src_hit = 1'b1;
    else                  src_hit = tick_in;
  end

  assign inc = run & gate_ok & src_hit;

  // R6
  stopped_no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !inc);
  // R6
  gate_closed_no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.gate_en && (gate_s == cfg.gate_pol)) |-> !inc);
endmodule

// File: rtl/gct_counter.sv
module gct_counter #(
  parameter int BYTE_W = 8,
  parameter int M0_LOW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              wide,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              ovf
);
  logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic              wrap, carry, wr_any;

  assign wr_any = wr_lo | wr_hi;

  always_comb begin
    lo_n  = lo_q;
    hi_n  = hi_q;
    carry = 1'b0;
    wrap  = 1'b0;
    if (wide) begin
      {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
      wrap = &{hi_q, lo_q};
    end else begin
      lo_n[M0_LOW-1:0] = lo_q[M0_LOW-1:0] + 1'b1;
      carry = &lo_q[M0_LOW-1:0];
      if (carry) hi_n = hi_q + 1'b1;
      wrap = carry & (&hi_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_any) begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end else if (inc) begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ovf <= 1'b0;
    else if (inc && !wr_any && wrap) ovf <= 1'b1;
    else if (ovf_clr)               ovf <= 1'b0;
  end

  assign lo = lo_q;
  assign hi = hi_q;

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(wdata));
  // R11
  other_byte_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> $stable(hi_q));
  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_any) |=> ($stable(lo_q) && $stable(hi_q)));
  // R8
  m0_upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !wr_lo) |=> lo_q[BYTE_W-1:M0_LOW] == $past(lo_q[BYTE_W-1:M0_LOW]));
  // R10
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_any && wide && (&{hi_q, lo_q})) |=> (ovf && hi_q == '0 && lo_q == '0));
  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/gated_ctr_timer.sv
module gated_ctr_timer
  import gct_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M0_LOW      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  input  logic              tick_in,
  output logic              ovf_flag
);
  localparam int PAD_CTL = BYTE_W - 2;
  localparam int PAD_CFG = BYTE_W - CFG_W;

  logic        run_q;
  gct_cfg_t    cfg_q;
  logic [1:0]  pins_s;
  logic        pin_fall, inc;
  logic        wr_ctl, wr_cfg, wr_lo, wr_hi, ovf_clr;
  logic [BYTE_W-1:0] cnt_lo, cnt_hi;
  logic        ovf;

  assign wr_ctl  = reg_we && (reg_addr == ADDR_CTL);
  assign wr_cfg  = reg_we && (reg_addr == ADDR_CFG);
  assign wr_lo   = reg_we && (reg_addr == ADDR_LO);
  assign wr_hi   = reg_we && (reg_addr == ADDR_HI);
  assign ovf_clr = wr_ctl && !reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      if (wr_ctl) run_q <= reg_wdata[0];
      if (wr_cfg) cfg_q <= gct_cfg_t'(reg_wdata[CFG_W-1:0]);
    end
  end

  gct_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({gate_pin, cnt_pin}), .q(pins_s)
  );

  gct_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_s[0]), .fall(pin_fall)
  );

  gct_inc_sel u_sel (
    .clk(clk), .rst_n(rst_n), .run(run_q), .cfg(cfg_q),
    .gate_s(pins_s[1]), .pin_fall(pin_fall), .tick_in(tick_in), .inc(inc)
  );

  gct_counter #(.BYTE_W(BYTE_W), .M0_LOW(M0_LOW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .wide(cfg_q.wide),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(reg_wdata), .ovf_clr(ovf_clr),
    .lo(cnt_lo), .hi(cnt_hi), .ovf(ovf)
  );

  always_comb begin
    unique case (gct_addr_e'(reg_raddr))
      ADDR_CTL: reg_rdata = {{PAD_CTL{1'b0}}, ovf, run_q};
      ADDR_CFG: reg_rdata = {{PAD_CFG{1'b0}}, cfg_q};
      ADDR_LO:  reg_rdata = cnt_lo;
      default:  reg_rdata = cnt_hi;
    endcase
  end

  assign ovf_flag = ovf;

  // R10
  flag_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R7
  run_write_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !run_q) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

// File: tb/gated_ctr_timer_tb.sv
module gated_ctr_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [1:0] reg_raddr = '0;
  logic [7:0] reg_rdata;
  logic       cnt_pin = 1'b1;
  logic       gate_pin = 1'b0;
  logic       tick_in = 1'b0;
  logic       ovf_flag;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0] addr;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #4 clk = ~clk;

  gated_ctr_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .cnt_pin(cnt_pin), .gate_pin(gate_pin), .tick_in(tick_in), .ovf_flag(ovf_flag)
  );

  // monitor: pops expected readbacks and compares
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      @(negedge clk);
      reg_raddr = sb_q[0].addr;
      #1;
      n_run++;
      if (reg_rdata !== sb_q[0].exp) begin
        n_fail++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h",
                 sb_q[0].tag, sb_q[0].addr, reg_rdata, sb_q[0].exp);
      end
      void'(sb_q.pop_front());
    end
  end

  task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic check_flag(input logic e, input string tag);
    n_run++;
    if (ovf_flag !== e) begin
      n_fail++;
      $display("FAIL %s ovf_flag actual=%0b expected=%0b", tag, ovf_flag, e);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // run for n+1 enabled edges; control bit1 written as 1 keeps the flag
  task automatic run_window(input int n);
    wr(2'd0, 8'h03);
    repeat (n) @(negedge clk);
    wr(2'd0, 8'h02);
  endtask

  task automatic load(input logic [7:0] h, input logic [7:0] l);
    wr(2'd3, h);
    wr(2'd2, l);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_rd(2'd0, 8'h00, "R1 ctl");
    expect_rd(2'd1, 8'h00, "R1 cfg");
    expect_rd(2'd2, 8'h00, "R1 lo");
    expect_rd(2'd3, 8'h00, "R1 hi");
    check_flag(1'b0, "R1");

    // R2 readback of map
    wr(2'd1, 8'hFF);
    expect_rd(2'd1, 8'h1F, "R2 cfg mask");
    load(8'h12, 8'h34);
    expect_rd(2'd2, 8'h34, "R2 lo");
    expect_rd(2'd3, 8'h12, "R2 hi");

    // R3 R9 R7 system clock, 16-bit, start value kept
    wr(2'd1, 8'h11);
    run_window(9);
    expect_rd(2'd2, 8'h3E, "R3 R7 lo");
    expect_rd(2'd3, 8'h12, "R9 hi");
    expect_rd(2'd0, 8'h00, "R2 ctl after stop");

    // R9 R10 16-bit wrap
    load(8'hFF, 8'hFE);
    run_window(2);
    expect_rd(2'd2, 8'h01, "R9 wrap lo");
    expect_rd(2'd3, 8'h00, "R9 wrap hi");
    expect_rd(2'd0, 8'h02, "R10 flag set 16b");
    check_flag(1'b1, "R10");
    wr(2'd0, 8'h00);
    expect_rd(2'd0, 8'h00, "R10 clear by write 0");
    check_flag(1'b0, "R10 cleared");

    // R8 R10 13-bit wrap, upper lo bits hold
    wr(2'd1, 8'h10);
    load(8'hFF, 8'hFE);
    run_window(2);
    expect_rd(2'd2, 8'hE1, "R8 wrap lo");
    expect_rd(2'd3, 8'h00, "R8 wrap hi");
    expect_rd(2'd0, 8'h02, "R10 flag set 13b");
    wr(2'd0, 8'h00);

    // R8 carry from 5 bits into high byte
    load(8'h10, 8'h3F);
    run_window(0);
    expect_rd(2'd2, 8'h20, "R8 carry lo");
    expect_rd(2'd3, 8'h11, "R8 carry hi");
    expect_rd(2'd0, 8'h00, "R8 no flag");

    // R4 prescaled tick source
    wr(2'd1, 8'h01);
    load(8'h00, 8'h00);
    wr(2'd0, 8'h03);
    for (int i = 0; i < 5; i++) begin
      tick_in = 1'b1; @(negedge clk);
      tick_in = 1'b0; repeat (2) @(negedge clk);
    end
    wr(2'd0, 8'h02);
    expect_rd(2'd2, 8'h05, "R4 ticks");

    // R5 pin source, src_sys also set
    wr(2'd1, 8'h19);
    load(8'h00, 8'h00);
    wr(2'd0, 8'h03);
    for (int i = 0; i < 4; i++) begin
      cnt_pin = 1'b0; repeat (4) @(negedge clk);
      cnt_pin = 1'b1; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h02);
    expect_rd(2'd2, 8'h04, "R5 edges");

    // R6 gating, gate pin held low
    wr(2'd1, 8'h13);
    load(8'h00, 8'h00);
    run_window(6);
    expect_rd(2'd2, 8'h00, "R6 high-active gate closed");
    wr(2'd1, 8'h17);
    run_window(6);
    expect_rd(2'd2, 8'h07, "R6 low-active gate open");
    wr(2'd1, 8'h11);
    run_window(6);
    expect_rd(2'd2, 8'h0E, "R6 gate disabled");

    // R11 write during counting cancels that increment
    load(8'h40, 8'h10);
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h55);
    wr(2'd0, 8'h02);
    expect_rd(2'd2, 8'h56, "R11 lo");
    expect_rd(2'd3, 8'h40, "R11 hi");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule